// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Three-Sample Voting

This block turns an asynchronous serial line into received characters. It looks at the line once on every pulse of an oversampling enable that runs at sixteen times the bit rate. It finds a start edge and confirms it, then recovers every bit by taking the majority of three samples near the middle of the bit. Each character has a start bit, eight data bits (nine in wide mode), least significant bit first, and one stop bit. The line passes through a two-flop synchronizer before any sampling.

A finished character is held in a one-entry output register and offered on a valid/ready interface. `out_valid` rises when a character is loaded. It stays high, with the data, ninth bit and framing flag unchanged, until the consumer raises `out_ready` in the same cycle, which is the transfer. A character that completes while the register is still full is dropped, because there is no room for it. The loss is noted internally, and the visible overrun flag takes up that note only at the next transfer. A consumer therefore reads `ovr_flag` after a transfer to learn whether anything was lost before the character it has just taken.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset `out_valid`, `out_ferr`, `out_bit8` and `ovr_flag` are 0, and the receiver is searching for a start edge.
- R2: While idle, the first low sample on a `samp_tick` is sample 1 of a start bit. If two or more of samples 8, 9 and 10 are high, the start is discarded, nothing is delivered, and the search for the next low sample begins again.
- R3: Each data bit takes the value held by at least two of its samples 8, 9 and 10, so one wrong sample among those three does not change the character.
- R4: Data bits arrive least significant bit first. At the end of each character `out_valid` is raised and `out_data` holds the eight low data bits, bit 0 being the first bit after the start bit.
- R5: The stop bit is valid when the majority of its samples 8 to 10 are high. Otherwise `out_ferr` is 1 together with that character, which is still delivered. `out_ferr` is 0 whenever `out_valid` is 0.
- R6: With `wide_mode` high at the start edge a character has nine data bits, and the ninth appears on `out_bit8`. In eight-bit mode `out_bit8` is 0.
- R7: A transfer happens in a cycle where `out_valid` and `out_ready` are both 1. Until then the held data and flags do not change. After a transfer with no new character `out_valid` is 0.
- R8: A character that completes while `out_valid` is 1 and no transfer occurs is discarded, and the held character is kept. `ovr_flag` changes only at a transfer. It then shows whether any character was discarded since the previous transfer.
- R9: While `rx_en` is 0 the receiver stays idle and ignores the line, and no character is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| wide_mode | input | 1 | 1 selects nine data bits per character |
| samp_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| out_valid | output | 1 | Held character available |
| out_ready | input | 1 | Consumer takes the held character |
| out_data | output | 8 | Received data bits 7..0 |
| out_bit8 | output | 1 | Ninth data bit in wide mode |
| out_ferr | output | 1 | Stop bit of the held character was invalid |
| ovr_flag | output | 1 | A character was lost before the last transfer |

## Verification
The assertions assume that `samp_tick` is a single-cycle pulse with at least three clocks between pulses. This lets the synchronized line settle between samples. They also assume `rx_en` changes only while no stop bit is being evaluated. The bench produces a tick every fourth clock and changes the line only just after a tick. It toggles the enable and the mode only while the line is idle. `out_ready` is raised only for single cycles, between frames or while a frame is in flight, so the hold, empty and buffered-overrun properties are exercised both with and without a transfer.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_slot_timer.sv
module rx_slot_timer
  import uart_rx_pkg::*;
#(
  parameter int OSR     = 16,
  parameter int VOTE_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic launch,
  input  logic active,
  output logic vote,
  output logic bit_v
);
  localparam int CW = $clog2(OSR + 1);
  localparam int VOTE_HI = VOTE_LO + 2;
  localparam logic [CW-1:0] SLOT_LAST  = CW'(OSR);
  localparam logic [CW-1:0] SLOT_FIRST = CW'(1);
  localparam logic [CW-1:0] SLOT_AFTER_EDGE = CW'(2);
  localparam logic [CW-1:0] SLOT_LO = CW'(VOTE_LO);
  localparam logic [CW-1:0] SLOT_HI = CW'(VOTE_HI);

  logic [CW-1:0] slot;
  logic [1:0]    early;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot  <= SLOT_FIRST;
      early <= 2'b11;
    end else if (launch) begin
      slot <= SLOT_AFTER_EDGE;
    end else if (tick && active) begin
      if (slot >= SLOT_LO && slot < SLOT_HI) early <= {early[0], rx};
      slot <= (slot == SLOT_LAST) ? SLOT_FIRST : slot + 1'b1;
    end
  end

  assign vote  = tick && active && (slot == SLOT_HI);
  assign bit_v = maj3({early, rx});
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wide_sel,
  input  logic          tick,
  input  logic          rx,
  input  logic          vote,
  input  logic          bit_v,
  output logic          launch,
  output logic          active,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          ferr
);
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] IDX_WIDE   = IW'(DW - 1);
  localparam logic [IW-1:0] IDX_NARROW = IW'(DW - 2);

  rx_state_e     state;
  logic [IW-1:0] idx;
  logic          wide_q;
  logic [IW-1:0] idx_last;

  assign launch   = enable && tick && (state == ST_HUNT) && !rx;
  assign active   = (state != ST_HUNT);
  assign idx_last = wide_q ? IDX_WIDE : IDX_NARROW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_HUNT;
      idx    <= '0;
      wide_q <= 1'b0;
      word   <= '0;
      ferr   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state <= ST_HUNT;
      end else begin
        unique case (state)
          ST_HUNT: if (launch) begin
            state  <= ST_START;
            wide_q <= wide_sel;
          end
          ST_START: if (vote) begin
            state <= bit_v ? ST_HUNT : ST_DATA;
            idx   <= '0;
            word  <= '0;
          end
          ST_DATA: if (vote) begin
            word[idx] <= bit_v;
            if (idx == idx_last) state <= ST_STOP;
            else                 idx   <= idx + 1'b1;
          end
          ST_STOP: if (vote) begin
            ferr  <= !bit_v;
            done  <= 1'b1;
            state <= ST_HUNT;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          load_ferr,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] word,
  output logic          ferr,
  output logic          ovr
);
  logic take;
  logic pend;

  assign take = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (take) begin
        ovr  <= pend;
        pend <= 1'b0;
      end
      if (load && (!valid || take)) begin
        word  <= load_word;
        ferr  <= load_ferr;
        valid <= 1'b1;
      end else if (load) begin
        pend <= 1'b1;
      end else if (take) begin
        valid <= 1'b0;
        ferr  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx #(
  parameter int OSR         = 16,
  parameter int VOTE_LO     = 8,
  parameter int DW          = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          wide_mode,
  input  logic          samp_tick,
  input  logic          rx_line,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-2:0] out_data,
  output logic          out_bit8,
  output logic          out_ferr,
  output logic          ovr_flag
);
  logic          rx_s;
  logic          launch;
  logic          active;
  logic          vote;
  logic          bit_v;
  logic          frame_done;
  logic [DW-1:0] frame_word;
  logic          frame_ferr;
  logic [DW-1:0] held_word;

  rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  rx_slot_timer #(.OSR(OSR), .VOTE_LO(VOTE_LO)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(samp_tick), .rx(rx_s),
    .launch(launch), .active(active), .vote(vote), .bit_v(bit_v)
  );

  rx_frame_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(rx_en), .wide_sel(wide_mode),
    .tick(samp_tick), .rx(rx_s), .vote(vote), .bit_v(bit_v),
    .launch(launch), .active(active), .done(frame_done),
    .word(frame_word), .ferr(frame_ferr)
  );

  rx_holding #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .load_word(frame_word),
    .load_ferr(frame_ferr), .ready(out_ready), .valid(out_valid),
    .word(held_word), .ferr(out_ferr), .ovr(ovr_flag)
  );

  assign out_data = held_word[DW-2:0];
  assign out_bit8 = held_word[DW-1];
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ferr,
  input logic              ovr_flag,
  input logic              frame_done
);
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ferr)); // R7

  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !frame_done |=> !out_valid); // R7

  AST_OVR_MOVES_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> $stable(ovr_flag)); // R8

  AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_valid); // R4

  AST_FERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_ferr); // R5

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !$past(rx_en) |-> !frame_done); // R9
endmodule

bind uart_mv_rx rx_checker #(.DATA_W(DW - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_ferr(out_ferr),
  .ovr_flag(ovr_flag), .frame_done(frame_done)
);

// File: tb/tb_uart_mv_rx.sv
`timescale 1ns/1ps
module tb_uart_mv_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1;
  logic       wide_mode = 1'b0;
  logic       samp_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_bit8;
  logic       out_ferr;
  logic       ovr_flag;

  int n_checks = 0;
  int n_fail = 0;
  int tdiv = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    samp_tick = (tdiv == 3);
    tdiv = (tdiv + 1) % 4;
  end

  uart_mv_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wide_mode(wide_mode),
    .samp_tick(samp_tick), .rx_line(rx_line), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_bit8(out_bit8),
    .out_ferr(out_ferr), .ovr_flag(ovr_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!samp_tick) @(posedge clk);
    end
    #1;
  endtask

  // one bit period of 16 samples; a slot in 1..16 given by flip carries the opposite level
  task automatic send_bit(input logic v, input int flip);
    for (int s = 1; s <= 16; s++) begin
      rx_line = (s == flip) ? ~v : v;
      wait_ticks(1);
    end
  endtask

  task automatic send_frame(input logic [8:0] w, input int nbits, input logic stop_v, input int flip);
    send_bit(1'b0, flip);
    for (int b = 0; b < nbits; b++) send_bit(w[b], flip);
    send_bit(stop_v, flip);
    rx_line = 1'b1;
    wait_ticks(20);
  endtask

  task automatic take();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", out_valid, 0);
    check("R1 ferr", out_ferr, 0);
    check("R1 bit8", out_bit8, 0);
    check("R1 ovr", ovr_flag, 0);
  endtask

  task automatic t_basic();
    send_frame(9'h0A5, 8, 1'b1, 0);
    @(negedge clk);
    check("R4 valid", out_valid, 1);
    check("R4 data lsb first", out_data, 8'hA5);
    check("R5 clean stop", out_ferr, 0);
    check("R6 bit8 narrow", out_bit8, 0);
    take();
    check("R7 emptied", out_valid, 0);
  endtask

  task automatic t_majority();
    send_frame(9'h03C, 8, 1'b1, 9);
    @(negedge clk);
    check("R3 slot9 flipped", out_data, 8'h3C);
    take();
    send_frame(9'h0C1, 8, 1'b1, 10);
    @(negedge clk);
    check("R3 slot10 flipped", out_data, 8'hC1);
    check("R3 valid", out_valid, 1);
    take();
  endtask

  task automatic t_glitch();
    rx_line = 1'b0;
    wait_ticks(3);
    rx_line = 1'b1;
    wait_ticks(40);
    @(negedge clk);
    check("R2 glitch dropped", out_valid, 0);
    send_frame(9'h05A, 8, 1'b1, 0);
    @(negedge clk);
    check("R2 recovers", out_data, 8'h5A);
    take();
  endtask

  task automatic t_framing();
    send_frame(9'h096, 8, 1'b0, 0);
    @(negedge clk);
    check("R5 delivered", out_valid, 1);
    check("R5 ferr", out_ferr, 1);
    check("R5 data", out_data, 8'h96);
    take();
    check("R5 ferr cleared", out_ferr, 0);
  endtask

  task automatic t_wide();
    wide_mode = 1'b1;
    send_frame(9'h1C3, 9, 1'b1, 0);
    @(negedge clk);
    check("R6 wide data", out_data, 8'hC3);
    check("R6 wide bit8", out_bit8, 1);
    check("R6 wide ferr", out_ferr, 0);
    take();
    wide_mode = 1'b0;
    send_frame(9'h07E, 8, 1'b1, 0);
    @(negedge clk);
    check("R6 narrow bit8", out_bit8, 0);
    check("R6 narrow data", out_data, 8'h7E);
    take();
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 8, 1'b1, 0);
    send_frame(9'h022, 8, 1'b1, 0);
    @(negedge clk);
    check("R8 held kept", out_data, 8'h11);
    check("R8 buffered", ovr_flag, 0);
    take();
    check("R8 ovr after take", ovr_flag, 1);
    check("R8 empty", out_valid, 0);
    send_frame(9'h033, 8, 1'b1, 0);
    @(negedge clk);
    check("R8 ovr stays until take", ovr_flag, 1);
    check("R8 next data", out_data, 8'h33);
    take();
    check("R8 ovr cleared", ovr_flag, 0);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    send_frame(9'h0F0, 8, 1'b1, 0);
    @(negedge clk);
    check("R9 ignored", out_valid, 0);
    rx_en = 1'b1;
    wait_ticks(4);
    send_frame(9'h0E7, 8, 1'b1, 0);
    @(negedge clk);
    check("R9 re-enabled", out_data, 8'hE7);
    take();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    wait_ticks(4);
    t_basic();
    t_majority();
    t_glitch();
    t_framing();
    t_wide();
    t_overrun();
    t_disabled();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule